// File: doc/BRIEF.md
# Reciprocal Period Timestamp Unit

This block measures how long one cycle of an external signal lasts. It records the moment of two successive rising edges against a free-running counter that advances once per system clock. Software, or a sequencer nearby, sends a one-cycle start pulse to arm the unit. The unit then goes through three steps: idle, started and done. After it captures the second edge it turns capture off by itself. A downstream divider turns the difference of the two timestamps into a frequency.

The external signal first passes through a two-flop synchronizer. It then goes through a glitch filter, which accepts a new level only after that level has been seen on several consecutive clock samples. Rising edges are taken from the filtered level. Every edge latches the counter value and raises a pending-event flag. The flag is raised even when capture is off. The start pulse discards any such stale event before it enables capture. A wrap-extension counter counts how many times the timestamp counter has rolled over. This lets long intervals be reconstructed.

Top module: `recip_ts_unit`

## Requirements
- R1: After reset the unit is disarmed. step_o reads 0, done_o reads 0, and both timestamps and ext_o read 0. Edges on sig_i before the first start pulse leave all of these unchanged.
- R2: A start pulse puts step_o at 0 and done_o at 0 on the next cycle, and it enables capture. An edge that arrived before the pulse is discarded and does not move the step.
- R3: The step encoding is 0 = idle, 1 = started, 2 = done, and 3 never occurs. With capture enabled at step 0, the first accepted rising edge loads start_ts_o and moves the step to 1.
- R4: At step 1 the next accepted rising edge loads stop_ts_o, turns capture off and moves the step to 2. done_o is high exactly while the step is 2.
- R5: While capture is off, rising edges change neither the step, done_o nor either timestamp.
- R6: A level on sig_i is accepted only after FILT_LEN (default 4) consecutive equal synchronized samples. A shorter pulse produces no edge.
- R7: For clean input levels, (stop_ts_o − start_ts_o) mod 2^CNT_W equals the number of clock cycles between the two rising edges.
- R8: The timestamp counter advances by one every cycle and rolls from all ones to 0. ext_o increments by one on each roll and holds otherwise.
- R9: A start pulse given while the step is 1 abandons that measurement. The next accepted edge becomes a new start timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timestamp time base |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that arms a new measurement |
| sig_i | input | 1 | Asynchronous signal under test |
| start_ts_o | output | CNT_W | Counter value at the first accepted rising edge |
| stop_ts_o | output | CNT_W | Counter value at the second accepted rising edge |
| ext_o | output | EXT_W | Number of timestamp counter roll-overs |
| step_o | output | 2 | Sequence step: 0 idle, 1 started, 2 done |
| done_o | output | 1 | High while the step is 2 |

## Verification
Square waves of different shapes are measured: a symmetric wave, a minimal four-high/five-low wave that sits exactly at the filter threshold, and a long wave whose interval crosses a counter roll-over. Together they separate a correct timestamp difference from filter latency errors, from off-by-one errors at the filter boundary, and from modular arithmetic errors. A three-cycle glitch placed between the two real edges must not be taken as the stop edge. Edges sent while the unit is done, before the first arm, and just before a re-arm tell a correctly discarded pending event apart from a spurious capture. A re-arm in the middle of a measurement checks that the abandoned start is replaced.

// File: rtl/recip_pkg.sv
package recip_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE    = 2'd0,
    STEP_STARTED = 2'd1,
    STEP_DONE    = 2'd2
  } step_t;
endpackage

// File: rtl/recip_sync.sv
module recip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/recip_filter.sv
module recip_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o
);
  localparam int HW = FILT_LEN - 1;

  logic [HW-1:0] hist_q;
  logic          level_q;
  logic          level_d1_q;
  logic          all_hi;
  logic          all_lo;

  assign all_hi = &{hist_q, d_i};
  assign all_lo = ~|{hist_q, d_i};

  generate
    if (HW == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[HW-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q    <= 1'b0;
      level_d1_q <= 1'b0;
    end else begin
      if (all_hi)      level_q <= 1'b1;
      else if (all_lo) level_q <= 1'b0;
      level_d1_q <= level_q;
    end
  end

  assign rise_o = level_q & ~level_d1_q;
endmodule

// File: rtl/recip_tsctr.sv
module recip_tsctr #(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic [EXT_W-1:0] ext_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] ext_q;
  logic             wrap;

  assign wrap = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) ext_q <= ext_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/recip_seq.sv
module recip_seq
  import recip_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] start_ts_o,
  output logic [CNT_W-1:0] stop_ts_o,
  output step_t            step_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cap_q;
  logic             pend_q;
  logic             en_q;
  logic             take;
  step_t            step_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] stop_q;
  logic             done_q;

  assign take = en_q & pend_q;

  // Captured-edge register and pending flag: set on every edge, like a
  // hardware capture channel, whether or not capture is enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (rise_i) cap_q <= cnt_i;
      if (start_i)     pend_q <= 1'b0;
      else if (rise_i) pend_q <= 1'b1;
      else if (take)   pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      step_q  <= STEP_IDLE;
      start_q <= '0;
      stop_q  <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      en_q   <= 1'b1;
      step_q <= STEP_IDLE;
      done_q <= 1'b0;
    end else if (take) begin
      case (step_q)
        STEP_IDLE: begin
          start_q <= cap_q;
          step_q  <= STEP_STARTED;
        end
        STEP_STARTED: begin
          stop_q <= cap_q;
          en_q   <= 1'b0;
          step_q <= STEP_DONE;
          done_q <= 1'b1;
        end
        default: begin
          en_q   <= 1'b0;
          step_q <= STEP_IDLE;
          done_q <= 1'b0;
        end
      endcase
    end
  end

  assign start_ts_o = start_q;
  assign stop_ts_o  = stop_q;
  assign step_o     = step_q;
  assign done_o     = done_q;
endmodule

// File: rtl/recip_ts_unit.sv
module recip_ts_unit
  import recip_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EXT_W       = 16,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sig_i,
  output logic [CNT_W-1:0] start_ts_o,
  output logic [CNT_W-1:0] stop_ts_o,
  output logic [EXT_W-1:0] ext_o,
  output logic [1:0]       step_o,
  output logic             done_o
);
  logic             sig_s;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  step_t            step;

  recip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(sig_i), .q_o(sig_s)
  );

  recip_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .d_i(sig_s), .rise_o(rise)
  );

  recip_tsctr #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_ctr (
    .clk(clk), .rst(rst), .cnt_o(cnt_q), .ext_o(ext_o)
  );

  recip_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .rise_i(rise), .cnt_i(cnt_q),
    .start_ts_o(start_ts_o), .stop_ts_o(stop_ts_o), .step_o(step),
    .done_o(done_o)
  );

  assign step_o = step;
endmodule

// File: rtl/recip_ts_chk.sv
module recip_ts_chk #(
  parameter int CNT_W = 32,
  parameter int EXT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [CNT_W-1:0] start_ts_o,
  input logic [CNT_W-1:0] stop_ts_o,
  input logic [EXT_W-1:0] ext_o,
  input logic [1:0]       step_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cnt_q
);
  AST_START_REARMS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (step_o == 2'd0 && !done_o)); // R2
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    step_o != 2'd3); // R3
  AST_NO_SKIP_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    (step_o == 2'd0) |=> (step_o != 2'd2)); // R4
  AST_DONE_TRACKS_STEP: assert property (@(posedge clk) disable iff (rst)
    done_o == (step_o == 2'd2)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(stop_ts_o) && $stable(start_ts_o))); // R5
  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1); // R8
  AST_EXT_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (&cnt_q) |=> ext_o == $past(ext_o) + 1'b1); // R8
  AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(&cnt_q) |=> $stable(ext_o)); // R8
endmodule

bind recip_ts_unit recip_ts_chk #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .start_ts_o(start_ts_o),
  .stop_ts_o(stop_ts_o), .ext_o(ext_o), .step_o(step_o), .done_o(done_o),
  .cnt_q(cnt_q)
);

// File: tb/tb_recip_ts_unit.sv
module tb_recip_ts_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int EXT_W = 8;
  localparam logic [CNT_W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sig_i = 1'b0;
  logic [CNT_W-1:0] start_ts_o, stop_ts_o;
  logic [EXT_W-1:0] ext_o;
  logic [1:0] step_o;
  logic done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recip_ts_unit #(.CNT_W(CNT_W), .EXT_W(EXT_W), .FILT_LEN(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sig_i(sig_i),
    .start_ts_o(start_ts_o), .stop_ts_o(stop_ts_o), .ext_o(ext_o),
    .step_o(step_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    sig_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic int diff_ts();
    logic [CNT_W-1:0] d;
    d = (stop_ts_o - start_ts_o) & MASK;
    return int'(d);
  endfunction

  task automatic t_reset();
    chk(step_o == 2'd0, "R1 step", step_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(start_ts_o == '0 && stop_ts_o == '0, "R1 ts", start_ts_o, 0);
    chk(ext_o == '0, "R1 ext", ext_o, 0);
    hold(1, 8); hold(0, 8); hold(1, 8); hold(0, 12);
    chk(step_o == 2'd0 && !done_o, "R1 edges before arm", step_o, 0);
    chk(start_ts_o == '0, "R1 start_ts untouched", start_ts_o, 0);
  endtask

  task automatic t_measure(input int hi, input int lo, input string req);
    hold(0, 8);
    pulse_start();
    hold(0, 4);
    hold(1, hi); hold(0, lo);
    hold(1, hi); hold(0, 14);
    chk(step_o == 2'd2, {req, " step done"}, step_o, 2);
    chk(done_o == 1'b1, {req, " done"}, done_o, 1);
    chk(diff_ts() == hi + lo, {req, " period"}, diff_ts(), hi + lo);
  endtask

  task automatic t_glitch();
    // R6: a 3-cycle high pulse between the real edges is rejected
    hold(0, 8);
    pulse_start();
    hold(0, 4);
    hold(1, 10); hold(0, 10); hold(1, 3); hold(0, 10);
    chk(step_o == 2'd1, "R6 glitch not stop edge", step_o, 1);
    hold(1, 10); hold(0, 14);
    chk(step_o == 2'd2, "R6 step", step_o, 2);
    chk(diff_ts() == 33, "R6 period spans glitch", diff_ts(), 33);
  endtask

  task automatic t_pending();
    logic [CNT_W-1:0] old_stop;
    old_stop = stop_ts_o;
    hold(1, 8); hold(0, 10);
    chk(step_o == 2'd2 && done_o, "R5 edge while done ignored", step_o, 2);
    chk(stop_ts_o == old_stop, "R5 stop_ts kept", stop_ts_o, old_stop);
    pulse_start();
    hold(0, 6);
    chk(step_o == 2'd0 && !done_o, "R2 stale edge discarded", step_o, 0);
    hold(1, 8); hold(0, 12);
    chk(step_o == 2'd1, "R3 first edge to started", step_o, 1);
    hold(1, 8); hold(0, 12);
    chk(step_o == 2'd2, "R4 second edge to done", step_o, 2);
    chk(diff_ts() == 20, "R7 rearmed period", diff_ts(), 20);
  endtask

  task automatic t_restart();
    logic [CNT_W-1:0] first_start;
    hold(0, 8);
    pulse_start();
    hold(0, 4);
    hold(1, 8); hold(0, 12);
    chk(step_o == 2'd1, "R9 started", step_o, 1);
    first_start = start_ts_o;
    pulse_start();
    chk(step_o == 2'd0 && !done_o, "R9 restart to idle", step_o, 0);
    hold(0, 4);
    hold(1, 6); hold(0, 10); hold(1, 6); hold(0, 14);
    chk(step_o == 2'd2, "R9 done after restart", step_o, 2);
    chk(diff_ts() == 16, "R9 new period", diff_ts(), 16);
    chk(start_ts_o != first_start, "R9 start_ts replaced", start_ts_o, first_start);
  endtask

  task automatic t_wrap();
    logic [EXT_W-1:0] e0;
    for (int k = 0; k < 2; k++) begin
      e0 = ext_o;
      repeat (1 << CNT_W) @(negedge clk);
      chk(ext_o == e0 + 1'b1, "R8 one wrap per 2^CNT_W cycles", ext_o, e0 + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_measure(10, 10, "R7 symmetric");
    t_measure(4, 5, "R6 threshold");
    t_pending();
    t_glitch();
    t_restart();
    t_wrap();
    t_measure(300, 300, "R7 across wrap");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule